// File: doc/BRIEF.md
# Dual-Operation Flash Bank Guard

This block is the request gate for a multi-bank NOR-style flash array. Every command, whether a read, program, block erase, suspend, resume or clear-status, is checked against a small record of the program/erase work in flight. The block answers with an accept or a reject pulse and keeps a status byte. It allows one bank to program or erase while reads continue in the other banks. It also supports the nesting a host needs: it can suspend an erase, run a program elsewhere, suspend that program, and read around both.

The word address is split into a bank field and a block field. Every bank holds 256K words. The ordinary banks hold eight 32K-word blocks. One parameter bank replaces one of its 32K regions with eight 4K-word blocks, which gives 135 blocks at the default size. A parameter places that bank and region at the top or the bottom of the map. A completion pulse from an external program/erase timer ends the running operation. The actual storage, the cell timing and the supplies are outside this block.

Top module: `flash_bank_guard`

## Requirements
- R1: After reset, status is 0x80 (ready only), no bank is busy, nothing is suspended, and neither accept nor reject pulses.
- R2: The bank is address bits [21:18], and a 32K block is bits [17:15]. With TOP_BOOT=1 the parameter bank is bank 15, and its 4K blocks (bits [14:12]) fill offsets 0x38000-0x3FFFF. With TOP_BOOT=0 it is bank 0, and the 4K blocks fill offsets 0x0000-0x7FFF. Two addresses in the same 4K (or 32K) block count as one block.
- R3: Opcodes are 0 read, 1 program, 2 erase, 3 suspend, 4 resume and 5 clear-status. Each command gives exactly one accept or reject pulse in the cycle after it. An accepted erase needs no program or erase outstanding. It raises bankBusy for its bank and clears status bit 7 (ready).
- R4: A program or erase issued while any operation runs unsuspended is rejected, and it sets the sticky conflict bit (status bit 5). At most one bankBusy bit is ever set.
- R5: A read is always accepted. readFromStatus is 1 when the read targets the bank of the running operation, or the target block of a suspended one. Otherwise it is 0.
- R6: A suspend while an erase runs makes eraseSuspended=1 (status bit 2) and frees the bank. A program is then accepted to any block except the suspended erase block. A program to that block is rejected with the conflict bit.
- R7: A suspend while a program runs makes progSuspended=1 (status bit 1). Reads of other blocks in that bank are served from the array.
- R8: A resume restarts a suspended program first. A suspended erase is resumed only when no program is outstanding.
- R9: opDone ends the running operation and clears its busy flag. An erase suspended beneath the program stays suspended. opDone has no effect when nothing runs.
- R10: A suspend with nothing running, or a resume that R8 cannot serve, is rejected and sets status bit 4 without changing any state. Opcodes 6 and 7 are rejected and set no error.
- R11: The error bits stay set until a clear-status command, which is always accepted.
- R12: opDone is dropped when a command arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Opcode |
| cmdAddr | input | 22 | Word address |
| opDone | input | 1 | Completion pulse from the program/erase timer |
| cmdAccept | output | 1 | Command accepted (one cycle later) |
| cmdReject | output | 1 | Command rejected (one cycle later) |
| readFromStatus | output | 1 | Accepted read returns status instead of array data |
| bankBusy | output | 16 | Per-bank running program/erase flag |
| progSuspended | output | 1 | A program is suspended |
| eraseSuspended | output | 1 | An erase is suspended |
| status | output | 8 | {ready, 0, conflict, seqErr, 0, eraseSusp, progSusp, 0} |

## Verification
The bench builds two copies with the default sizes: sixteen banks of 256K words, with 32K and 4K blocks. One copy uses TOP_BOOT=1 and the other TOP_BOOT=0. The top-boot copy runs the full nesting sequence and checks the 4K blocks at the top of bank 15. The bottom-boot copy checks that the small blocks sit at offset zero of bank 0 and that bank 15 then decodes as whole 32K blocks.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_PROG    = 3'd1,
    OP_ERASE   = 3'd2,
    OP_SUSPEND = 3'd3,
    OP_RESUME  = 3'd4,
    OP_CLEAR   = 3'd5
  } op_e;

  typedef struct packed {
    logic accept;
    logic reject;
    logic readStat;
    logic startProg;
    logic startErase;
    logic suspProg;
    logic suspErase;
    logic resumeProg;
    logic resumeErase;
    logic finishProg;
    logic finishErase;
    logic setSeqErr;
    logic setConflictErr;
    logic clearErr;
  } strobe_t;
endpackage

// File: rtl/fbg_decode.sv
module fbg_decode #(
  parameter int BANK_W   = 4,
  parameter int BANK_AW  = 18,
  parameter int MAIN_AW  = 15,
  parameter int PARAM_AW = 12,
  parameter bit TOP_BOOT = 1'b1,
  localparam int ADDR_W  = BANK_W + BANK_AW,
  localparam int MIDX_W  = BANK_AW - MAIN_AW,
  localparam int PIDX_W  = MAIN_AW - PARAM_AW,
  localparam int SUBL_W  = (MIDX_W > PIDX_W) ? MIDX_W : PIDX_W,
  localparam int KEY_W   = BANK_W + SUBL_W + 1
) (
  input  logic [ADDR_W-1:PARAM_AW] addrHi,
  output logic [KEY_W-1:0]         blockKey
);
  localparam int PARAM_BANK   = TOP_BOOT ? (2**BANK_W - 1) : 0;
  localparam int PARAM_REGION = TOP_BOOT ? (2**MIDX_W - 1) : 0;

  logic [BANK_W-1:0] bankIdx;
  logic [MIDX_W-1:0] mainIdx;
  logic [PIDX_W-1:0] paramIdx;
  logic              inParam;

  assign bankIdx  = addrHi[ADDR_W-1:BANK_AW];
  assign mainIdx  = addrHi[BANK_AW-1:MAIN_AW];
  assign paramIdx = addrHi[MAIN_AW-1:PARAM_AW];
  assign inParam  = (bankIdx == BANK_W'(PARAM_BANK)) && (mainIdx == MIDX_W'(PARAM_REGION));

  always_comb begin
    if (inParam) blockKey = {bankIdx, 1'b1, SUBL_W'(paramIdx)};
    else         blockKey = {bankIdx, 1'b0, SUBL_W'(mainIdx)};
  end
endmodule

// File: rtl/fbg_ctrl.sv
module fbg_ctrl
  import fbg_pkg::*;
#(
  parameter int KEY_W  = 8,
  parameter int BANK_W = 4
) (
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [KEY_W-1:0] blockKey,
  input  logic             opDone,
  input  logic             progValid,
  input  logic             progSusp,
  input  logic [KEY_W-1:0] progKey,
  input  logic             eraseValid,
  input  logic             eraseSusp,
  input  logic [KEY_W-1:0] eraseKey,
  output strobe_t          stb
);
  logic              progRun, eraseRun, anyRun;
  logic [BANK_W-1:0] runBank, reqBank;

  assign progRun  = progValid && !progSusp;
  assign eraseRun = eraseValid && !eraseSusp;
  assign anyRun   = progRun || eraseRun;
  assign runBank  = progRun ? progKey[KEY_W-1 -: BANK_W] : eraseKey[KEY_W-1 -: BANK_W];
  assign reqBank  = blockKey[KEY_W-1 -: BANK_W];

  always_comb begin
    stb = '0;
    if (cmdValid) begin
      unique case (cmdOp)
        OP_READ: begin
          stb.accept   = 1'b1;
          stb.readStat = (anyRun && reqBank == runBank)
                      || (progValid && progSusp && blockKey == progKey)
                      || (eraseValid && eraseSusp && blockKey == eraseKey);
        end
        OP_PROG: begin
          if (!progValid && !eraseRun && !(eraseValid && blockKey == eraseKey)) begin
            stb.accept    = 1'b1;
            stb.startProg = 1'b1;
          end else begin
            stb.reject         = 1'b1;
            stb.setConflictErr = 1'b1;
          end
        end
        OP_ERASE: begin
          if (!progValid && !eraseValid) begin
            stb.accept     = 1'b1;
            stb.startErase = 1'b1;
          end else begin
            stb.reject         = 1'b1;
            stb.setConflictErr = 1'b1;
          end
        end
        OP_SUSPEND: begin
          if (progRun) begin
            stb.accept   = 1'b1;
            stb.suspProg = 1'b1;
          end else if (eraseRun) begin
            stb.accept    = 1'b1;
            stb.suspErase = 1'b1;
          end else begin
            stb.reject    = 1'b1;
            stb.setSeqErr = 1'b1;
          end
        end
        OP_RESUME: begin
          if (progValid && progSusp) begin
            stb.accept     = 1'b1;
            stb.resumeProg = 1'b1;
          end else if (eraseValid && eraseSusp && !progValid) begin
            stb.accept      = 1'b1;
            stb.resumeErase = 1'b1;
          end else begin
            stb.reject    = 1'b1;
            stb.setSeqErr = 1'b1;
          end
        end
        OP_CLEAR: begin
          stb.accept   = 1'b1;
          stb.clearErr = 1'b1;
        end
        default: stb.reject = 1'b1;
      endcase
    end else if (opDone) begin
      stb.finishProg  = progRun;
      stb.finishErase = eraseRun && !progRun;
    end
  end
endmodule

// File: rtl/fbg_datapath.sv
module fbg_datapath
  import fbg_pkg::*;
#(
  parameter int KEY_W     = 8,
  parameter int BANK_W    = 4,
  localparam int NUM_BANKS = 2**BANK_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [KEY_W-1:0]     blockKey,
  output logic                 progValid,
  output logic                 progSusp,
  output logic [KEY_W-1:0]     progKey,
  output logic                 eraseValid,
  output logic                 eraseSusp,
  output logic [KEY_W-1:0]     eraseKey,
  output logic                 cmdAccept,
  output logic                 cmdReject,
  output logic                 readFromStatus,
  output logic [NUM_BANKS-1:0] bankBusy,
  output logic [7:0]           status
);
  logic seqErr, conflictErr, progRun, eraseRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progValid <= 1'b0; progSusp <= 1'b0; progKey <= '0;
      eraseValid <= 1'b0; eraseSusp <= 1'b0; eraseKey <= '0;
      cmdAccept <= 1'b0; cmdReject <= 1'b0; readFromStatus <= 1'b0;
      seqErr <= 1'b0; conflictErr <= 1'b0;
    end else begin
      cmdAccept      <= stb.accept;
      cmdReject      <= stb.reject;
      readFromStatus <= stb.readStat;
      if (stb.startProg) begin
        progValid <= 1'b1; progSusp <= 1'b0; progKey <= blockKey;
      end
      if (stb.suspProg)   progSusp  <= 1'b1;
      if (stb.resumeProg) progSusp  <= 1'b0;
      if (stb.finishProg) progValid <= 1'b0;
      if (stb.startErase) begin
        eraseValid <= 1'b1; eraseSusp <= 1'b0; eraseKey <= blockKey;
      end
      if (stb.suspErase)   eraseSusp  <= 1'b1;
      if (stb.resumeErase) eraseSusp  <= 1'b0;
      if (stb.finishErase) eraseValid <= 1'b0;
      if (stb.clearErr) begin
        seqErr <= 1'b0; conflictErr <= 1'b0;
      end else begin
        if (stb.setSeqErr)      seqErr      <= 1'b1;
        if (stb.setConflictErr) conflictErr <= 1'b1;
      end
    end
  end

  assign progRun  = progValid && !progSusp;
  assign eraseRun = eraseValid && !eraseSusp;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_busy
    assign bankBusy[b] = (progRun  && progKey[KEY_W-1 -: BANK_W]  == BANK_W'(b))
                      || (eraseRun && eraseKey[KEY_W-1 -: BANK_W] == BANK_W'(b));
  end

  assign status = {!(progRun || eraseRun), 1'b0, conflictErr, seqErr, 1'b0,
                   eraseValid && eraseSusp, progValid && progSusp, 1'b0};

  assert_one_bank_R4: assert property (@(posedge clk) disable iff (!rstN) $onehot0(bankBusy));
  assert_nested_under_erase_R6: assert property (@(posedge clk) disable iff (!rstN)
    (progValid && eraseValid) |-> eraseSusp);
  assert_ready_vs_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    status[7] == (bankBusy == '0));
  assert_one_answer_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdAccept && cmdReject));
  assert_seq_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (seqErr && !stb.clearErr) |=> seqErr);
  assert_conflict_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (conflictErr && !stb.clearErr) |=> conflictErr);
endmodule

// File: rtl/flash_bank_guard.sv
module flash_bank_guard
  import fbg_pkg::*;
#(
  parameter int BANK_W   = 4,
  parameter int BANK_AW  = 18,
  parameter int MAIN_AW  = 15,
  parameter int PARAM_AW = 12,
  parameter bit TOP_BOOT = 1'b1,
  localparam int NUM_BANKS = 2**BANK_W,
  localparam int ADDR_W    = BANK_W + BANK_AW,
  localparam int MIDX_W    = BANK_AW - MAIN_AW,
  localparam int PIDX_W    = MAIN_AW - PARAM_AW,
  localparam int KEY_W     = BANK_W + 1 + ((MIDX_W > PIDX_W) ? MIDX_W : PIDX_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdOp,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic                 opDone,
  output logic                 cmdAccept,
  output logic                 cmdReject,
  output logic                 readFromStatus,
  output logic [NUM_BANKS-1:0] bankBusy,
  output logic                 progSuspended,
  output logic                 eraseSuspended,
  output logic [7:0]           status
);
  logic [KEY_W-1:0] blockKey, progKey, eraseKey;
  logic             progValid, progSusp, eraseValid, eraseSusp;
  strobe_t          stb;

  fbg_decode #(.BANK_W(BANK_W), .BANK_AW(BANK_AW), .MAIN_AW(MAIN_AW),
               .PARAM_AW(PARAM_AW), .TOP_BOOT(TOP_BOOT)) i_decode (
    .addrHi(cmdAddr[ADDR_W-1:PARAM_AW]), .blockKey(blockKey));

  fbg_ctrl #(.KEY_W(KEY_W), .BANK_W(BANK_W)) i_ctrl (
    .cmdValid(cmdValid), .cmdOp(cmdOp), .blockKey(blockKey), .opDone(opDone),
    .progValid(progValid), .progSusp(progSusp), .progKey(progKey),
    .eraseValid(eraseValid), .eraseSusp(eraseSusp), .eraseKey(eraseKey), .stb(stb));

  fbg_datapath #(.KEY_W(KEY_W), .BANK_W(BANK_W)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .blockKey(blockKey),
    .progValid(progValid), .progSusp(progSusp), .progKey(progKey),
    .eraseValid(eraseValid), .eraseSusp(eraseSusp), .eraseKey(eraseKey),
    .cmdAccept(cmdAccept), .cmdReject(cmdReject), .readFromStatus(readFromStatus),
    .bankBusy(bankBusy), .status(status));

  assign progSuspended  = progValid && progSusp;
  assign eraseSuspended = eraseValid && eraseSusp;

  assert_read_taken_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_READ) |=> cmdAccept);
  assert_bad_resume_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_RESUME && !progSuspended && !eraseSuspended) |=> (cmdReject && status[4]));
  assert_bad_suspend_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_SUSPEND && status[7]) |=> (cmdReject && status[4]));
endmodule

// File: tb/test_flash_bank_guard.sv
module test_flash_bank_guard;
  localparam int AW = 22;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, opDone = 1'b0, useBot = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [AW-1:0] cmdAddr = '0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  logic accT, rejT, rsT, psT, esT, accB, rejB, rsB, psB, esB;
  logic [15:0] busyT, busyB;
  logic [7:0] stT, stB;

  flash_bank_guard #(.TOP_BOOT(1'b1)) i_flash_bank_guard (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid && !useBot), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .opDone(opDone && !useBot), .cmdAccept(accT), .cmdReject(rejT), .readFromStatus(rsT),
    .bankBusy(busyT), .progSuspended(psT), .eraseSuspended(esT), .status(stT));

  flash_bank_guard #(.TOP_BOOT(1'b0)) i_flash_bank_guard_bottom (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid && useBot), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .opDone(opDone && useBot), .cmdAccept(accB), .cmdReject(rejB), .readFromStatus(rsB),
    .bankBusy(busyB), .progSuspended(psB), .eraseSuspended(esB), .status(stB));

  function automatic logic [AW-1:0] blk(int b, int i);
    return AW'((b << 18) | (i << 15));
  endfunction
  function automatic logic [AW-1:0] pblk(int b, int j, int base);
    return AW'((b << 18) | base | (j << 12));
  endfunction
  function automatic logic [51:0] mkv(logic [2:0] op, logic [AW-1:0] a, logic ac, logic rj,
                                      logic rs, logic [7:0] st, logic [15:0] bz);
    return {op, a, ac, rj, rs, st, bz};
  endfunction

  localparam logic [51:0] VEC [NV] = '{
    mkv(3'd2, blk(3,2),         1,0,0, 8'h00, 16'h0008),
    mkv(3'd0, blk(5,0),         1,0,0, 8'h00, 16'h0008),
    mkv(3'd0, blk(3,5),         1,0,1, 8'h00, 16'h0008),
    mkv(3'd1, blk(5,1),         0,1,0, 8'h20, 16'h0008),
    mkv(3'd3, blk(0,0),         1,0,0, 8'hA4, 16'h0000),
    mkv(3'd0, blk(3,5),         1,0,0, 8'hA4, 16'h0000),
    mkv(3'd0, blk(3,2) + 'h123, 1,0,1, 8'hA4, 16'h0000),
    mkv(3'd1, blk(3,2) + 'h40,  0,1,0, 8'hA4, 16'h0000),
    mkv(3'd5, blk(0,0),         1,0,0, 8'h84, 16'h0000),
    mkv(3'd1, blk(3,4),         1,0,0, 8'h04, 16'h0008),
    mkv(3'd0, blk(7,0),         1,0,0, 8'h04, 16'h0008),
    mkv(3'd3, blk(0,0),         1,0,0, 8'h86, 16'h0000),
    mkv(3'd0, blk(3,4) + 'h10,  1,0,1, 8'h86, 16'h0000),
    mkv(3'd0, blk(3,6),         1,0,0, 8'h86, 16'h0000),
    mkv(3'd0, blk(3,2),         1,0,1, 8'h86, 16'h0000),
    mkv(3'd3, blk(0,0),         0,1,0, 8'h96, 16'h0000),
    mkv(3'd2, blk(9,0),         0,1,0, 8'hB6, 16'h0000),
    mkv(3'd5, blk(0,0),         1,0,0, 8'h86, 16'h0000),
    mkv(3'd4, blk(0,0),         1,0,0, 8'h04, 16'h0008),
    mkv(3'd4, blk(0,0),         0,1,0, 8'h14, 16'h0008),
    mkv(3'd6, blk(0,0),         0,1,0, 8'h14, 16'h0008),
    mkv(3'd5, blk(0,0),         1,0,0, 8'h04, 16'h0008)
  };

  function automatic string reqOf(logic [2:0] op);
    case (op)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R3";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic dn);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; opDone = dn;
    @(negedge clk);
    cmdValid = 1'b0; opDone = 1'b0;
  endtask

  task automatic done();
    @(negedge clk); opDone = 1'b1;
    @(negedge clk); opDone = 1'b0;
  endtask

  function automatic logic [7:0] st(); return useBot ? stB : stT; endfunction
  function automatic logic [15:0] busy(); return useBot ? busyB : busyT; endfunction
  function automatic logic rs(); return useBot ? rsB : rsT; endfunction
  function automatic logic acc(); return useBot ? accB : accT; endfunction
  function automatic logic rej(); return useBot ? rejB : rejT; endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state on both builds
    chk("R1", "status top", 32'(stT), 32'h80);
    chk("R1", "busy top", 32'(busyT), 32'h0);
    chk("R1", "answer top", {30'd0, accT, rejT}, 32'h0);
    chk("R1", "susp top", {30'd0, psT, esT}, 32'h0);
    chk("R1", "status bottom", 32'(stB), 32'h80);
    chk("R1", "busy bottom", 32'(busyB), 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [51:0] e;
      e = VEC[v];
      cmd(e[51:49], e[48:27], 1'b0);
      chk(reqOf(e[51:49]), $sformatf("accept v%0d", v), 32'(acc()), 32'(e[26]));
      chk(reqOf(e[51:49]), $sformatf("reject v%0d", v), 32'(rej()), 32'(e[25]));
      chk(reqOf(e[51:49]), $sformatf("readStat v%0d", v), 32'(rs()), 32'(e[24]));
      chk(reqOf(e[51:49]), $sformatf("status v%0d", v), 32'(st()), 32'(e[23:16]));
      chk(reqOf(e[51:49]), $sformatf("busy v%0d", v), 32'(busy()), 32'(e[15:0]));
    end
    chk("R7", "progSuspended after resume", 32'(psT), 32'h0);
    chk("R6", "eraseSuspended held", 32'(esT), 32'h1);

    // R9 nested program completes, erase stays suspended
    done();
    chk("R9", "status after prog done", 32'(st()), 32'h84);
    chk("R9", "busy after prog done", 32'(busy()), 32'h0);
    chk("R9", "erase still suspended", 32'(esT), 32'h1);
    cmd(3'd4, '0, 1'b0);
    chk("R8", "erase resumed status", 32'(st()), 32'h00);
    chk("R8", "erase resumed busy", 32'(busy()), 32'h0008);
    done();
    chk("R9", "erase done status", 32'(st()), 32'h80);
    done();
    chk("R9", "idle done ignored", 32'(st()), 32'h80);

    // R2 top-boot parameter blocks in bank 15
    cmd(3'd2, pblk(15, 3, 'h38000), 1'b0);
    chk("R2", "param erase busy", 32'(busy()), 32'h8000);
    cmd(3'd3, '0, 1'b0);
    cmd(3'd0, blk(15, 6), 1'b0);
    chk("R2", "main block beside params", 32'(rs()), 32'h0);
    cmd(3'd0, pblk(15, 3, 'h38000) + 'hFF, 1'b0);
    chk("R2", "same 4K block", 32'(rs()), 32'h1);
    cmd(3'd0, pblk(15, 2, 'h38000), 1'b0);
    chk("R2", "neighbour 4K block", 32'(rs()), 32'h0);
    cmd(3'd1, pblk(15, 3, 'h38000) + 'h1, 1'b0);
    chk("R6", "prog into suspended erase block", 32'(rej()), 32'h1);
    cmd(3'd5, '0, 1'b0);
    cmd(3'd4, '0, 1'b0);
    done();
    chk("R9", "param erase finished", 32'(st()), 32'h80);

    // R12 done dropped when a command shares the cycle
    cmd(3'd2, blk(2, 0), 1'b0);
    cmd(3'd0, blk(6, 0), 1'b1);
    chk("R12", "read accepted", 32'(acc()), 32'h1);
    chk("R12", "done dropped", 32'(busy()), 32'h0004);
    done();
    chk("R12", "later done ends erase", 32'(st()), 32'h80);

    // R2 bottom-boot build
    useBot = 1'b1;
    cmd(3'd2, pblk(0, 1, 0), 1'b0);
    chk("R2", "bottom busy bank0", 32'(busy()), 32'h0001);
    cmd(3'd3, '0, 1'b0);
    cmd(3'd0, pblk(0, 2, 0), 1'b0);
    chk("R2", "bottom next 4K block", 32'(rs()), 32'h0);
    cmd(3'd0, pblk(0, 1, 0) + 'hFFF, 1'b0);
    chk("R2", "bottom same 4K block", 32'(rs()), 32'h1);
    cmd(3'd0, blk(0, 1), 1'b0);
    chk("R2", "bottom main block", 32'(rs()), 32'h0);
    cmd(3'd4, '0, 1'b0);
    done();
    cmd(3'd2, blk(15, 7) + 'h1000, 1'b0);
    cmd(3'd3, '0, 1'b0);
    cmd(3'd0, blk(15, 7) + 'h7000, 1'b0);
    chk("R2", "bottom bank15 whole 32K block", 32'(rs()), 32'h1);
    chk("R6", "bottom status", 32'(st()), 32'h84);
    cmd(3'd1, blk(15, 0), 1'b0);
    chk("R6", "prog during erase suspend", 32'(acc()), 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule